// File: doc/BRIEF.md
# Time-of-Day Alarm and Interrupt Unit

This unit watches a running BCD time and date and raises an alarm whenever that time agrees with one of two programmable alarm settings. The first alarm has fields for seconds, minutes, hours and a day-or-date value. The second alarm has no seconds field and can only trigger at second 00. Bit 7 of every alarm byte is a mask. A masked field takes no part in the comparison, so the set of mask bits sets how often an alarm repeats. The comparison is made only on the cycle in which the once-per-second update strobe is high.

Each alarm sets a sticky flag. Software clears a flag by writing 0 to it. One active-low output pin serves two purposes, selected by a control bit. In interrupt mode the pin is held low for as long as any enabled flag is set. In square-wave mode the pin carries a clock derived from a 32.768 kHz reference pulse train, at one of four selectable rates. The time counter itself lies outside this block and supplies the time fields and the strobe.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset the control byte (address 7) reads 0x1C: interrupt-select (bit 2) is 1, rate (bits 4:3) is 11, and both alarm enables (bit 0 for alarm 1, bit 1 for alarm 2) are 0. The status byte (address 8) reads 0x00, and `irq_n` is high.
- R2: When all four mask bits of alarm 1 are 1, the alarm 1 flag (status bit 0) is set on every update strobe.
- R3: An alarm field whose bit 7 is 0 must match the current field (bits 6:0) for the alarm to fire. A field whose bit 7 is 1 is excluded from the comparison. Alarm 1 uses addresses 0 to 3 (seconds, minutes, hours, day/date).
- R4: In a day/date alarm byte, bit 6 selects the comparison target: 0 compares bits 5:0 with the date of the month, and 1 compares them with the day of the week.
- R5: Alarm 2 (addresses 4 to 6: minutes, hours, day/date) sets status bit 1 only when the current seconds are 00. With all its mask bits set, it fires once per minute.
- R6: The hours comparison covers bits 6:0, which include the 12/24 bit and the AM/PM bit. An alarm hour given in a different format never matches.
- R7: Matches are evaluated only on cycles where `upd_tick` is 1. Matching fields with no strobe set no flag.
- R8: A flag is set on a match whatever the enable and select bits are. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A match in the same cycle wins over a clear.
- R9: With interrupt-select at 1, `irq_n` is low while (flag1 AND enable1) OR (flag2 AND enable2). It stays low for as long as that holds, and goes high once it no longer does.
- R10: With interrupt-select at 0, `irq_n` is a square wave. The frequency is 1 Hz, 1.024 kHz, 4.096 kHz or 8.192 kHz for rate 00, 01, 10 or 11. That gives half-periods of 16384, 16, 4 or 2 reference pulses.
- R11: Alarm and control bytes read back as written on `rd_data` for the address on `rd_addr`. Status bits 7:2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_tick | input | 1 | Once-per-second update strobe, one cycle wide |
| ref_en | input | 1 | Reference pulse at 32.768 kHz rate, one cycle wide |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours with 12/24 (bit 6) and AM/PM or tens (bit 5) |
| cur_wday | input | 6 | Current day of week |
| cur_mday | input | 6 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_n | output | 1 | Active-low interrupt or square-wave output |

## Verification
The bench steps through the mask stages of both alarms. It drives times that are off by one field, which would catch a design that ignores a mask bit or compares a masked field. It offers alarm 2 a matching minute at a nonzero second, which exposes a design that forgets the implied seconds condition. It writes an alarm hour in 12-hour form against a 24-hour time, and tests both meanings of the day/date select bit. It writes 1s to set flags to catch a design that treats the status byte as plain storage, and holds the interrupt across idle cycles to catch a pulse-style output. It measures each square-wave half-period, which catches a swapped or wrongly tapped rate.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

   localparam int REG_ADDR_W  = 4;
   localparam int NUM_ALARMS  = 2;
   localparam int NUM_ALM_REG = 7;

   // register addresses
   localparam logic [REG_ADDR_W-1:0] ADR_A1_SEC  = 4'd0;
   localparam logic [REG_ADDR_W-1:0] ADR_A1_MIN  = 4'd1;
   localparam logic [REG_ADDR_W-1:0] ADR_A1_HOUR = 4'd2;
   localparam logic [REG_ADDR_W-1:0] ADR_A1_DD   = 4'd3;
   localparam logic [REG_ADDR_W-1:0] ADR_A2_MIN  = 4'd4;
   localparam logic [REG_ADDR_W-1:0] ADR_A2_HOUR = 4'd5;
   localparam logic [REG_ADDR_W-1:0] ADR_A2_DD   = 4'd6;
   localparam logic [REG_ADDR_W-1:0] ADR_CTRL    = 4'd7;
   localparam logic [REG_ADDR_W-1:0] ADR_STAT    = 4'd8;

   // control byte layout
   typedef struct packed {
      logic [1:0] rate;
      logic       irq_sel;
      logic       ie2;
      logic       ie1;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{rate: 2'b11, irq_sel: 1'b1, ie2: 1'b0, ie1: 1'b0};

   // alarm byte fields
   localparam int MASK_BIT = 7;
   localparam int DDSEL_BIT = 6;

   function automatic logic field_ok(input logic [7:0] alm, input logic [6:0] cur);
      return alm[MASK_BIT] | (alm[6:0] == cur);
   endfunction

endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
   import tod_alarm_pkg::*;
(
   input  logic       upd_tick,
   input  logic [6:0] cur_sec,
   input  logic [6:0] cur_min,
   input  logic [6:0] cur_hour,
   input  logic [5:0] cur_wday,
   input  logic [5:0] cur_mday,
   input  logic [7:0] alm_sec,
   input  logic [7:0] alm_min,
   input  logic [7:0] alm_hour,
   input  logic [7:0] alm_dd,
   output logic       hit
);

   logic sec_ok, min_ok, hour_ok, dd_ok;
   logic [5:0] dd_target;

   always_comb begin
      sec_ok    = field_ok(alm_sec, cur_sec);
      min_ok    = field_ok(alm_min, cur_min);
      hour_ok   = field_ok(alm_hour, cur_hour);
      dd_target = alm_dd[DDSEL_BIT] ? cur_wday : cur_mday;
      dd_ok     = alm_dd[MASK_BIT] | (alm_dd[5:0] == dd_target);
      hit       = upd_tick & sec_ok & min_ok & hour_ok & dd_ok;
   end

endmodule

// File: rtl/tod_sqw_div.sv
module tod_sqw_div #(
   parameter int REF_HZ = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic [1:0] rate,
   output logic       wave
);

   localparam int DIV_W   = $clog2(REF_HZ);
   localparam int TAP_1HZ = DIV_W - 1;
   localparam int TAP_1K  = $clog2(REF_HZ / 1024) - 1;
   localparam int TAP_4K  = $clog2(REF_HZ / 4096) - 1;
   localparam int TAP_8K  = $clog2(REF_HZ / 8192) - 1;

   if ((1 << DIV_W) != REF_HZ) begin : g_bad_ref
      $error("REF_HZ must be a power of two");
   end
   if (REF_HZ < 16384) begin : g_low_ref
      $error("REF_HZ too low for the fastest rate");
   end

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (ref_en) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      unique case (rate)
         2'b00: wave = cnt_q[TAP_1HZ];
         2'b01: wave = cnt_q[TAP_1K];
         2'b10: wave = cnt_q[TAP_4K];
         default: wave = cnt_q[TAP_8K];
      endcase
   end

   AST_SQW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rate) && !$past(ref_en)) |-> $stable(wave)); // R10

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
   import tod_alarm_pkg::*;
#(
   parameter int REF_HZ = 32768
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_tick,
   input  logic                  ref_en,
   input  logic [6:0]            cur_sec,
   input  logic [6:0]            cur_min,
   input  logic [6:0]            cur_hour,
   input  logic [5:0]            cur_wday,
   input  logic [5:0]            cur_mday,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [7:0]            rd_data,
   output logic                  irq_n
);

   logic [7:0]            alm_q [NUM_ALM_REG];
   ctrl_t                 ctrl_q;
   logic [NUM_ALARMS-1:0] flag_q;
   logic [NUM_ALARMS-1:0] hit;
   logic [NUM_ALARMS-1:0] ie;
   logic                  wave;
   logic                  stat_wr;

   assign stat_wr = wr_en && (wr_addr == ADR_STAT);
   assign ie      = {ctrl_q.ie2, ctrl_q.ie1};

   // alarm byte storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ALM_REG; i++) alm_q[i] <= 8'h00;
      end else if (wr_en && (wr_addr < REG_ADDR_W'(NUM_ALM_REG))) begin
         alm_q[wr_addr[2:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RESET;
      else if (wr_en && (wr_addr == ADR_CTRL)) ctrl_q <= ctrl_t'(wr_data[4:0]);
   end

   // per-alarm comparators; the second alarm has an implied seconds == 00
   for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alm
      logic [7:0] s_b, m_b, h_b, d_b;
      if (g == 0) begin : g_first
         assign s_b = alm_q[ADR_A1_SEC[2:0]];
         assign m_b = alm_q[ADR_A1_MIN[2:0]];
         assign h_b = alm_q[ADR_A1_HOUR[2:0]];
         assign d_b = alm_q[ADR_A1_DD[2:0]];
      end else begin : g_second
         assign s_b = 8'h00;
         assign m_b = alm_q[ADR_A2_MIN[2:0]];
         assign h_b = alm_q[ADR_A2_HOUR[2:0]];
         assign d_b = alm_q[ADR_A2_DD[2:0]];
      end

      tod_alarm_match u_match (
         .upd_tick (upd_tick),
         .cur_sec  (cur_sec),
         .cur_min  (cur_min),
         .cur_hour (cur_hour),
         .cur_wday (cur_wday),
         .cur_mday (cur_mday),
         .alm_sec  (s_b),
         .alm_min  (m_b),
         .alm_hour (h_b),
         .alm_dd   (d_b),
         .hit      (hit[g])
      );

      // sticky flag: set by match, cleared only by writing 0
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[g] <= 1'b0;
         else flag_q[g] <= hit[g] | (flag_q[g] & ~(stat_wr & ~wr_data[g]));
      end

      AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_q[g]) |-> $past(upd_tick)); // R7
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[g] && !stat_wr) |=> flag_q[g]); // R8
      AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_wr && !wr_data[g] && !hit[g]) |=> !flag_q[g]); // R8
   end

   tod_sqw_div #(.REF_HZ(REF_HZ)) u_sqw (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .rate   (ctrl_q.rate),
      .wave   (wave)
   );

   assign irq_n = ctrl_q.irq_sel ? ~|(flag_q & ie) : wave;

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr < REG_ADDR_W'(NUM_ALM_REG)) rd_data = alm_q[rd_addr[2:0]];
      else if (rd_addr == ADR_CTRL) rd_data = {3'b000, ctrl_q};
      else if (rd_addr == ADR_STAT) rd_data = {{(8-NUM_ALARMS){1'b0}}, flag_q};
   end

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && ctrl_q.irq_sel && !stat_wr && !(wr_en && wr_addr == ADR_CTRL)) |=> !irq_n); // R9

endmodule

// File: tb/tod_alarm_irq_test.sv
module tod_alarm_irq_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd_tick = 1'b0;
   logic ref_en = 1'b1;
   logic [6:0] cur_sec = 7'h01, cur_min = 7'h01, cur_hour = 7'h01;
   logic [5:0] cur_wday = 6'd1, cur_mday = 6'h01;
   logic wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_busy = 1'b0;

   typedef struct {
      string      tag;
      logic [3:0] addr;
      logic [7:0] data;
      bit         chk_irq;
      logic       irq;
   } item_t;
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tod_alarm_irq uut (
      .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .ref_en(ref_en),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_wday(cur_wday), .cur_mday(cur_mday),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
   );

   task automatic report(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares at the negative edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            item_t it;
            mon_busy = 1'b1;
            it = exp_q.pop_front();
            rd_addr = it.addr;
            #1;
            report({it.tag, " rd_data"}, rd_data, it.data);
            if (it.chk_irq) report({it.tag, " irq_n"}, irq_n, it.irq);
            mon_busy = 1'b0;
         end
      end
   end

   task automatic expect_rd(input string tag, input logic [3:0] a, input logic [7:0] d,
                            input bit ci, input logic ir);
      item_t it;
      it.tag = tag; it.addr = a; it.data = d; it.chk_irq = ci; it.irq = ir;
      exp_q.push_back(it);
      wait (exp_q.size() == 0 && !mon_busy);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                           input logic [5:0] wd, input logic [5:0] md);
      cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd; cur_mday = md;
   endtask

   task automatic tick_at(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                          input logic [5:0] wd, input logic [5:0] md);
      @(negedge clk);
      set_time(s, m, h, wd, md);
      upd_tick = 1'b1;
      @(negedge clk);
      upd_tick = 1'b0;
   endtask

   task automatic half_period(input string tag, input int exp);
      logic prev;
      int cnt;
      int edges;
      edges = 0; cnt = 0;
      @(negedge clk); prev = irq_n;
      while (edges < 3) begin
         @(negedge clk);
         cnt++;
         if (irq_n != prev) begin
            edges++;
            if (edges == 3) report(tag, cnt, exp);
            cnt = 0;
            prev = irq_n;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_rd("R1 ctrl", 4'd7, 8'h1C, 1, 1'b1);
      expect_rd("R1 status", 4'd8, 8'h00, 1, 1'b1);

      // R2 fully masked alarm 1 fires on a tick; R8 flag set without enables
      wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
      tick_at(7'h10, 7'h11, 7'h12, 6'd2, 6'h05);
      expect_rd("R2 every-second fire", 4'd8, 8'h01, 1, 1'b1);
      wr(4'd8, 8'hFF);
      expect_rd("R8 write 1 keeps flag", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);
      expect_rd("R8 write 0 clears", 4'd8, 8'h00, 0, 1'b1);

      // R7 matching time without strobe
      set_time(7'h10, 7'h11, 7'h12, 6'd2, 6'h05);
      repeat (4) @(negedge clk);
      expect_rd("R7 no strobe no flag", 4'd8, 8'h00, 0, 1'b1);

      // R3 seconds stage, then minutes+seconds stage
      wr(4'd0, 8'h30);
      tick_at(7'h29, 7'h11, 7'h12, 6'd2, 6'h05);
      expect_rd("R3 seconds mismatch", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h30, 7'h11, 7'h12, 6'd2, 6'h05);
      expect_rd("R3 seconds match", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);
      wr(4'd1, 8'h15);
      tick_at(7'h30, 7'h16, 7'h12, 6'd2, 6'h05);
      expect_rd("R3 minutes mismatch", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h30, 7'h15, 7'h12, 6'd2, 6'h05);
      expect_rd("R3 minutes+seconds match", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);

      // R6 hour format bits take part
      wr(4'd2, 8'h45);
      tick_at(7'h30, 7'h15, 7'h05, 6'd2, 6'h05);
      expect_rd("R6 24h vs 12h no match", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h30, 7'h15, 7'h45, 6'd2, 6'h05);
      expect_rd("R6 12h match", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);

      // R4 day-of-week vs date select
      wr(4'd3, 8'h43);
      tick_at(7'h30, 7'h15, 7'h45, 6'd3, 6'h05);
      expect_rd("R4 weekday match", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);
      tick_at(7'h30, 7'h15, 7'h45, 6'd4, 6'h03);
      expect_rd("R4 weekday select ignores date", 4'd8, 8'h00, 0, 1'b1);
      wr(4'd3, 8'h15);
      tick_at(7'h30, 7'h15, 7'h45, 6'd3, 6'h15);
      expect_rd("R4 date match", 4'd8, 8'h01, 0, 1'b1);
      wr(4'd8, 8'h00);
      tick_at(7'h30, 7'h15, 7'h45, 6'd5, 6'h14);
      expect_rd("R4 date mismatch", 4'd8, 8'h00, 0, 1'b1);

      // R11 readback
      expect_rd("R11 a1 hour", 4'd2, 8'h45, 0, 1'b1);
      expect_rd("R11 a1 daydate", 4'd3, 8'h15, 0, 1'b1);

      // R5 alarm 2 stages
      wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
      tick_at(7'h01, 7'h21, 7'h12, 6'd2, 6'h05);
      expect_rd("R5 masked not at sec 01", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h00, 7'h21, 7'h12, 6'd2, 6'h05);
      expect_rd("R5 masked fires at sec 00", 4'd8, 8'h02, 0, 1'b1);
      wr(4'd8, 8'h00);
      wr(4'd4, 8'h22);
      tick_at(7'h00, 7'h21, 7'h12, 6'd2, 6'h05);
      expect_rd("R5 minute mismatch", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h05, 7'h22, 7'h12, 6'd2, 6'h05);
      expect_rd("R5 minute match at sec 05", 4'd8, 8'h00, 0, 1'b1);
      tick_at(7'h00, 7'h22, 7'h12, 6'd2, 6'h05);
      expect_rd("R5 minute match at sec 00", 4'd8, 8'h02, 0, 1'b1);
      wr(4'd8, 8'h00);
      expect_rd("R11 a2 minutes", 4'd4, 8'h22, 0, 1'b1);

      // R9 interrupt level
      wr(4'd7, 8'h05);
      expect_rd("R11 ctrl readback", 4'd7, 8'h05, 1, 1'b1);
      wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
      tick_at(7'h10, 7'h11, 7'h12, 6'd2, 6'h05);
      expect_rd("R9 enabled flag asserts", 4'd8, 8'h01, 1, 1'b0);
      repeat (6) @(negedge clk);
      expect_rd("R9 level held", 4'd8, 8'h01, 1, 1'b0);
      wr(4'd8, 8'h00);
      expect_rd("R9 released after clear", 4'd8, 8'h00, 1, 1'b1);
      wr(4'd7, 8'h06);
      tick_at(7'h00, 7'h22, 7'h12, 6'd2, 6'h05);
      expect_rd("R9 alarm 2 enabled", 4'd8, 8'h03, 1, 1'b0);
      wr(4'd7, 8'h04);
      expect_rd("R9 no enables no irq", 4'd8, 8'h03, 1, 1'b1);
      wr(4'd8, 8'h00);

      // R10 square-wave rates (ref_en every cycle)
      wr(4'd7, 8'h18);
      half_period("R10 rate 11", 2);
      wr(4'd7, 8'h10);
      half_period("R10 rate 10", 4);
      wr(4'd7, 8'h08);
      half_period("R10 rate 01", 16);
      wr(4'd7, 8'h00);
      half_period("R10 rate 00", 16384);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule